// File: doc/BRIEF.md
# Handshake multi-port memory

This block is a single on-chip array shared by several load ports and several store ports. Every port is a valid/ready channel. A load port takes an address token and answers with two tokens: the word read from the array and a completion token that carries no payload. A store port takes an address token and a data token, writes the word, and answers with a payload-free completion token. Array depth, word width, incoming address width and the number of load and store ports are parameters. Conflicting writes to one row in the same cycle are not arbitrated; the producer side keeps them apart.

All input channels share one flat bus: `in_valid`, `in_ready` and `in_payload`, with each channel's payload in a slot `PAY_W = max(DATA_W, ADDR_W)` bits wide. All output channels share `out_valid`, `out_ready` and `out_data`. Only the load-data channels carry a payload, so `out_data` holds `N_LD` words. A producer presents a store's address and data together and holds them until they are accepted. A store channel's ready does not wait for its partner channel to be valid. `ADDR_W` must be at least `ceil(log2(DEPTH))`.

Top module: `hsk_memory`

## Requirements
- R1: Input channel `2*s` is the data of store port s, and channel `2*s+1` is its address. Channel `2*N_ST+l` is the address of load port l. Output channel l is the data of load port l. Channel `N_LD+s` is the completion of store port s. Channel `N_LD+N_ST+l` is the completion of load port l.
- R2: While a load address is valid, the load data word equals the array row at the truncated address in the same cycle, with no register in the path.
- R3: A valid load address offers each of its two outputs until that output has been taken once. The address is accepted in the cycle in which both outputs have been taken, in that cycle or earlier. The address ready is never high while the address valid is low.
- R4: A store writes the array only at a clock edge where its address and data are both valid and its ready is high. The new word is visible to loads from the next cycle.
- R5: The ready of a store's address channel and of its data channel are equal. Both are high exactly when the store's completion is not pending or the completion is being taken.
- R6: A store's completion valid comes from a register. When the store's ready is high, the register takes (address valid AND data valid). Otherwise it keeps its value, so the completion appears one cycle after the write is accepted.
- R7: A store whose completion is pending and not taken accepts nothing and does not write, even while a new address/data pair is valid.
- R8: Every address is reduced to its low `ceil(log2(DEPTH))` bits before it indexes the array, so addresses that differ only above those bits alias.
- R9: After reset, every array row is zero, every store completion valid is 0, and every load has taken nothing yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2*N_ST+N_LD | Valid of each input channel |
| in_ready | output | 2*N_ST+N_LD | Ready of each input channel |
| in_payload | input | (2*N_ST+N_LD)*PAY_W | Payload slot of each input channel |
| out_valid | output | 2*N_LD+N_ST | Valid of each output channel |
| out_ready | input | 2*N_LD+N_ST | Ready of each output channel |
| out_data | output | N_LD*DATA_W | Read word of each load-data channel |

## Verification
The case that is hardest to reach from the ports is a store whose completion is pending and not taken while a fresh address/data pair is already valid. That pair must neither be accepted nor written. A directed sequence holds one store's completion ready low over two pairs to the same row, then reads the row back. A long randomized phase throttles every completion ready independently and changes load addresses in the middle of a fork. This reaches partially taken forks and aliased addresses, and a behavioural model checks every output on every cycle.

// File: rtl/hsk_mem_pkg.sv
package hsk_mem_pkg;

  // Index bits that address the array.
  function automatic int row_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Input channel positions.
  function automatic int st_data_ch(input int s);
    return 2 * s;
  endfunction

  function automatic int st_addr_ch(input int s);
    return 2 * s + 1;
  endfunction

  function automatic int ld_addr_ch(input int n_st, input int l);
    return 2 * n_st + l;
  endfunction

  // Output channel positions.
  function automatic int st_done_out(input int n_ld, input int s);
    return n_ld + s;
  endfunction

  function automatic int ld_done_out(input int n_ld, input int n_st, input int l);
    return n_ld + n_st + l;
  endfunction

endpackage

// File: rtl/hsk_store_ctl.sv
module hsk_store_ctl (
  input  logic clk,
  input  logic rst,
  input  logic addr_valid,
  input  logic data_valid,
  input  logic done_ready,
  output logic chan_ready,
  output logic done_valid,
  output logic commit
);
  logic done_q;

  // A pending completion blocks new pairs unless it leaves this cycle.
  assign chan_ready = !done_q || done_ready;
  assign commit     = chan_ready && addr_valid && data_valid;
  assign done_valid = done_q;

  always_ff @(posedge clk) begin
    if (rst)             done_q <= 1'b0;
    else if (chan_ready) done_q <= addr_valid && data_valid;
  end
endmodule

// File: rtl/hsk_load_fork.sv
module hsk_load_fork (
  input  logic clk,
  input  logic rst,
  input  logic addr_valid,
  input  logic data_ready,
  input  logic done_ready,
  output logic addr_ready,
  output logic data_valid,
  output logic done_valid
);
  logic sent_d_q, sent_c_q;
  logic take_d, take_c;

  assign data_valid = addr_valid && !sent_d_q;
  assign done_valid = addr_valid && !sent_c_q;
  assign take_d     = sent_d_q || (data_valid && data_ready);
  assign take_c     = sent_c_q || (done_valid && done_ready);
  assign addr_ready = addr_valid && take_d && take_c;

  always_ff @(posedge clk) begin
    if (rst || (addr_valid && addr_ready)) begin
      sent_d_q <= 1'b0;
      sent_c_q <= 1'b0;
    end else if (addr_valid) begin
      sent_d_q <= take_d;
      sent_c_q <= take_c;
    end
  end
endmodule

// File: rtl/hsk_memory.sv
module hsk_memory
  import hsk_mem_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 8,
  parameter  int N_LD   = 2,
  parameter  int N_ST   = 2,
  localparam int IN_CH  = 2 * N_ST + N_LD,
  localparam int OUT_CH = 2 * N_LD + N_ST,
  localparam int PAY_W  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_CH-1:0]        in_valid,
  output logic [IN_CH-1:0]        in_ready,
  input  logic [IN_CH*PAY_W-1:0]  in_payload,
  output logic [OUT_CH-1:0]       out_valid,
  input  logic [OUT_CH-1:0]       out_ready,
  output logic [N_LD*DATA_W-1:0]  out_data
);
  localparam int LAW  = row_bits(DEPTH);
  localparam int ROWS = 1 << LAW;

  // Named internal events, one per port.
  logic [N_ST-1:0]   st_we;
  logic [LAW-1:0]    st_idx   [N_ST];
  logic [DATA_W-1:0] st_wdata [N_ST];
  logic [N_LD-1:0]   ld_take;
  logic [LAW-1:0]    ld_idx   [N_LD];

  logic [DATA_W-1:0] mem_q [ROWS];

  for (genvar s = 0; s < N_ST; s++) begin : g_st
    localparam int CD = st_data_ch(s);
    localparam int CA = st_addr_ch(s);
    localparam int CO = st_done_out(N_LD, s);
    logic rdy, dv, commit;
    logic [ADDR_W-1:0] raw_addr;

    hsk_store_ctl u_ctl (
      .clk        (clk),
      .rst        (rst),
      .addr_valid (in_valid[CA]),
      .data_valid (in_valid[CD]),
      .done_ready (out_ready[CO]),
      .chan_ready (rdy),
      .done_valid (dv),
      .commit     (commit)
    );

    assign raw_addr      = in_payload[CA*PAY_W +: ADDR_W];
    assign in_ready[CA]  = rdy;
    assign in_ready[CD]  = rdy;
    assign out_valid[CO] = dv;
    assign st_we[s]      = commit;
    assign st_idx[s]     = raw_addr[LAW-1:0];
    assign st_wdata[s]   = in_payload[CD*PAY_W +: DATA_W];
  end

  for (genvar l = 0; l < N_LD; l++) begin : g_ld
    localparam int CL = ld_addr_ch(N_ST, l);
    localparam int OC = ld_done_out(N_LD, N_ST, l);
    logic ardy, dval, cval;
    logic [ADDR_W-1:0] raw_addr;

    hsk_load_fork u_fork (
      .clk        (clk),
      .rst        (rst),
      .addr_valid (in_valid[CL]),
      .data_ready (out_ready[l]),
      .done_ready (out_ready[OC]),
      .addr_ready (ardy),
      .data_valid (dval),
      .done_valid (cval)
    );

    assign raw_addr                   = in_payload[CL*PAY_W +: ADDR_W];
    assign ld_idx[l]                  = raw_addr[LAW-1:0];
    assign in_ready[CL]               = ardy;
    assign out_valid[l]               = dval;
    assign out_valid[OC]              = cval;
    assign ld_take[l]                 = in_valid[CL] && ardy;
    assign out_data[l*DATA_W +: DATA_W] = mem_q[ld_idx[l]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else begin
      for (int s = 0; s < N_ST; s++)
        if (st_we[s]) mem_q[st_idx[s]] <= st_wdata[s];
    end
  end
endmodule

// File: rtl/hsk_memory_chk.sv
module hsk_memory_chk
  import hsk_mem_pkg::*;
#(
  parameter  int N_LD   = 2,
  parameter  int N_ST   = 2,
  localparam int IN_CH  = 2 * N_ST + N_LD,
  localparam int OUT_CH = 2 * N_LD + N_ST
) (
  input logic              clk,
  input logic              rst,
  input logic [IN_CH-1:0]  in_valid,
  input logic [IN_CH-1:0]  in_ready,
  input logic [OUT_CH-1:0] out_valid,
  input logic [OUT_CH-1:0] out_ready
);
  for (genvar s = 0; s < N_ST; s++) begin : g_st
    localparam int CD = st_data_ch(s);
    localparam int CA = st_addr_ch(s);
    localparam int CO = st_done_out(N_LD, s);

    assert_block_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid[CO] && !out_ready[CO]) |-> (!in_ready[CA] && !in_ready[CD]));

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid[CO] && !out_ready[CO]) |=> out_valid[CO]);

    assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid[CO]) |-> $past(in_valid[CA] && in_valid[CD] && in_ready[CA]));

    assert_reset_done_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid[CO]);
  end

  for (genvar l = 0; l < N_LD; l++) begin : g_ld
    localparam int CL = ld_addr_ch(N_ST, l);
    localparam int OC = ld_done_out(N_LD, N_ST, l);

    assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
      in_ready[CL] |-> in_valid[CL]);

    assert_data_once_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid[CL] && !in_ready[CL] && out_valid[l] && out_ready[l]) |=> !out_valid[l]);

    assert_done_once_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid[CL] && !in_ready[CL] && out_valid[OC] && out_ready[OC]) |=> !out_valid[OC]);
  end
endmodule

bind hsk_memory hsk_memory_chk #(.N_LD(N_LD), .N_ST(N_ST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/hsk_memory_test.sv
module hsk_memory_test;
  localparam int DEPTH = 16, DATA_W = 16, ADDR_W = 8, N_LD = 2, N_ST = 2;
  localparam int IN_CH = 2 * N_ST + N_LD, OUT_CH = 2 * N_LD + N_ST, PAY_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_CH-1:0]       in_valid;
  logic [IN_CH-1:0]       in_ready;
  logic [IN_CH*PAY_W-1:0] in_payload;
  logic [OUT_CH-1:0]      out_valid;
  logic [OUT_CH-1:0]      out_ready;
  logic [N_LD*DATA_W-1:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  hsk_memory #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_LD(N_LD), .N_ST(N_ST)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  // Bench view of the channels.
  bit st_av[N_ST], st_dv[N_ST], st_dr[N_ST];
  int st_addr[N_ST], st_data[N_ST];
  bit ld_v[N_LD], ld_dr[N_LD], ld_cr[N_LD];
  int ld_addr[N_LD];

  // Behavioural reference state.
  int ref_mem[DEPTH];
  bit ref_busy[N_ST];
  bit ref_sd[N_LD], ref_sc[N_LD];
  bit e_ldrdy[N_LD], e_strdy[N_ST];

  int errors = 0, checks = 0;

  // Channel mapping as stated in R1.
  always_comb begin
    in_valid = '0; in_payload = '0; out_ready = '0;
    for (int s = 0; s < N_ST; s++) begin
      in_valid[2*s]   = st_dv[s];
      in_valid[2*s+1] = st_av[s];
      in_payload[(2*s)*PAY_W +: PAY_W]   = st_data[s][PAY_W-1:0];
      in_payload[(2*s+1)*PAY_W +: PAY_W] = st_addr[s][PAY_W-1:0];
      out_ready[N_LD+s] = st_dr[s];
    end
    for (int l = 0; l < N_LD; l++) begin
      in_valid[2*N_ST+l] = ld_v[l];
      in_payload[(2*N_ST+l)*PAY_W +: PAY_W] = ld_addr[l][PAY_W-1:0];
      out_ready[l] = ld_dr[l];
      out_ready[N_LD+N_ST+l] = ld_cr[l];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    for (int s = 0; s < N_ST; s++) begin st_av[s] = 0; st_dv[s] = 0; st_dr[s] = 1; end
    for (int l = 0; l < N_LD; l++) begin ld_v[l] = 0; ld_dr[l] = 1; ld_cr[l] = 1; end
  endtask

  // One cycle: compare at negedge+1, then advance the model at posedge.
  task automatic cyc(input bit lit = 0, input int lit_l = 0, input int lit_v = 0, input string lit_req = "");
    bit av, ev_d, ev_c, td, tc;
    #1;
    for (int l = 0; l < N_LD; l++) begin
      av   = ld_v[l];
      ev_d = av && !ref_sd[l];
      ev_c = av && !ref_sc[l];
      td   = ref_sd[l] || (ev_d && ld_dr[l]);
      tc   = ref_sc[l] || (ev_c && ld_cr[l]);
      e_ldrdy[l] = av && td && tc;
      chk("R3", "load data valid", 32'(out_valid[l]), 32'(ev_d));
      chk("R3", "load done valid", 32'(out_valid[N_LD+N_ST+l]), 32'(ev_c));
      chk("R3", "load addr ready", 32'(in_ready[2*N_ST+l]), 32'(e_ldrdy[l]));
      if (av) chk("R2/R8", "load data", 32'(out_data[l*DATA_W +: DATA_W]), 32'(ref_mem[ld_addr[l] % DEPTH]));
    end
    for (int s = 0; s < N_ST; s++) begin
      e_strdy[s] = !ref_busy[s] || st_dr[s];
      chk("R5", "store addr ready", 32'(in_ready[2*s+1]), 32'(e_strdy[s]));
      chk("R5", "store data ready", 32'(in_ready[2*s]), 32'(e_strdy[s]));
      chk("R6", "store done valid", 32'(out_valid[N_LD+s]), 32'(ref_busy[s]));
    end
    if (lit) chk(lit_req, "directed read", 32'(out_data[lit_l*DATA_W +: DATA_W]), 32'(lit_v));
    @(posedge clk);
    for (int s = 0; s < N_ST; s++)
      if (e_strdy[s]) begin
        if (st_av[s] && st_dv[s]) ref_mem[st_addr[s] % DEPTH] = st_data[s] & 16'hFFFF;
        ref_busy[s] = st_av[s] && st_dv[s];
      end
    for (int l = 0; l < N_LD; l++)
      if (ld_v[l]) begin
        if (e_ldrdy[l]) begin ref_sd[l] = 0; ref_sc[l] = 0; end
        else begin
          ref_sd[l] = ref_sd[l] || (!ref_sd[l] && ld_dr[l]);
          ref_sc[l] = ref_sc[l] || (!ref_sc[l] && ld_cr[l]);
        end
      end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    for (int s = 0; s < N_ST; s++) begin st_addr[s] = 0; st_data[s] = 0; end
    for (int l = 0; l < N_LD; l++) ld_addr[l] = 0;
    for (int r = 0; r < DEPTH; r++) ref_mem[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state, zeroed row read back.
    ld_v[0] = 1; ld_addr[0] = 5;
    cyc(1, 0, 0, "R9");
    idle();

    // R1/R4: store port 0 writes row 3; store port 1 writes aliased row (R8).
    st_av[0] = 1; st_dv[0] = 1; st_addr[0] = 3; st_data[0] = 16'hAAAA;
    st_av[1] = 1; st_dv[1] = 1; st_addr[1] = 8'h27; st_data[1] = 16'h1234;
    ld_v[1] = 1; ld_addr[1] = 3;
    cyc(1, 1, 0, "R4");            // not yet visible in the write cycle
    idle();
    ld_v[1] = 1; ld_addr[1] = 3;
    ld_v[0] = 1; ld_addr[0] = 8'hF7;
    cyc(1, 1, 16'hAAAA, "R1/R4");
    cyc(1, 0, 16'h1234, "R8");
    idle();

    // R7: completion held, second pair must not be written.
    st_dr[0] = 0;
    st_av[0] = 1; st_dv[0] = 1; st_addr[0] = 9; st_data[0] = 16'h1111;
    cyc();
    st_data[0] = 16'h2222;
    cyc();
    cyc();
    st_av[0] = 0; st_dv[0] = 0;
    ld_v[0] = 1; ld_addr[0] = 9;
    cyc(1, 0, 16'h1111, "R7");
    st_dr[0] = 1;
    cyc();
    idle();

    // R3: data output stalled while done is taken.
    ld_v[0] = 1; ld_addr[0] = 9; ld_dr[0] = 0;
    cyc(); cyc();
    ld_dr[0] = 1;
    cyc();
    idle();

    // Randomized traffic over all ports.
    for (int n = 0; n < 4000; n++) begin
      for (int l = 0; l < N_LD; l++) begin
        ld_v[l] = ($urandom % 3) != 0;
        ld_addr[l] = $urandom % 256;
        ld_dr[l] = ($urandom % 4) != 0;
        ld_cr[l] = ($urandom % 4) != 0;
      end
      for (int s = 0; s < N_ST; s++) begin
        st_av[s] = ($urandom % 2) != 0;
        st_dv[s] = st_av[s];
        st_addr[s] = $urandom % 256;
        st_data[s] = $urandom % 65536;
        st_dr[s] = ($urandom % 4) != 0;
      end
      if ((st_addr[0] % DEPTH) == (st_addr[1] % DEPTH)) st_addr[1] = st_addr[1] ^ 1;
      cyc();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule